// File: doc/BRIEF.md
# Cycle Trace Ring Buffer

This block records a 256-bit trace word on every clock edge into an on-chip circular store, so that the recent history of a processor can be inspected after the fact. Capture runs freely and overwrites the oldest entry once the store is full. Two independent access ports share the store. One is meant for software running on the processor and the other for an external debug agent. Each port owns a 64-bit control word and a 64-bit data read path.

Through its control word a port can halt capture, so that the store stays still while it is read, and can position its own read cursor. The store is read out one 64-bit doubleword at a time, and every read advances that port's cursor. The control word also shows where capture will write next. The store length is merged into that field as a single marker bit, so the reader can work out the depth without any other register: the depth is 1 << (31 - leading-zero count of the control word). If the depth parameter is set to zero, no storage or capture logic is built and every output reads as zero.

Top module: `trace_ring`

## Requirements
- R1: On each clock edge where no port's halt flag is set, the trace input is stored at the capture index, and the capture index then advances by one, modulo DEPTH (DEPTH is a power of two, at least 2).
- R2: Bits 63:32 of each port's control word hold the capture index (counted in 256-bit entries) ORed with the value DEPTH. Decoding 1 << (31 - clz64(word)) therefore yields DEPTH.
- R3: Bit 31 of each port's control word is that port's halt flag. Bits 30:0 are that port's read cursor, counted in 64-bit doublewords.
- R4: A control write loads the halt flag from bit 31 of the write data and the read cursor from bits 30:0, masked to the range 0..4*DEPTH-1. Bits 63:32 of the write data have no effect, and the capture index cannot be written.
- R5: Capture stops on the first clock edge after either port's halt flag is set, and stays stopped while either flag is set. A single port that clears its flag does not resume capture while the other port's flag is still set.
- R6: A data read strobe returns, on the following cycle, the doubleword at the read cursor: entry cursor>>2, lane cursor[1:0], with lane 0 at bits 63:0. The output holds until the next read. The cursor then increments modulo 4*DEPTH. If a control write arrives in the same cycle, the written cursor takes precedence.
- R7: The two ports keep separate halt flags, read cursors and data outputs. Accesses on one port leave the other port's cursor and data unchanged.
- R8: After reset the capture index, both cursors and both halt flags are zero, and both data outputs are zero.
- R9: With DEPTH = 0, both control words and both data outputs are constant zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_in | input | 256 | Trace word captured each cycle |
| sw_ctl_we | input | 1 | Software port control write strobe |
| sw_ctl_wdata | input | 64 | Software port control write data |
| sw_data_re | input | 1 | Software port data read strobe |
| sw_ctl_rdata | output | 64 | Software port control word |
| sw_data_rdata | output | 64 | Software port read data |
| dbg_ctl_we | input | 1 | Debug port control write strobe |
| dbg_ctl_wdata | input | 64 | Debug port control write data |
| dbg_data_re | input | 1 | Debug port data read strobe |
| dbg_ctl_rdata | output | 64 | Debug port control word |
| dbg_data_rdata | output | 64 | Debug port read data |

## Verification
The bench runs capture past the end of the store. A design with a wrong wrap would report an index outside the store or read back stale entries. It halts capture from either port alone and then releases the ports one at a time. A design that ANDs the two flags, or resumes when only one port clears, would move the capture index while the bench expects it to stay put. It reads every doubleword of the store in order, all the way past the cursor wrap, against a model of the store, which exposes swapped lanes, an extra cycle of read latency and a cursor that fails to wrap. It also decodes the depth from the control word and checks that upper write-data bits and debug-port accesses leave the other fields alone.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
    localparam int ENT_W  = 256;
    localparam int DW_W   = 64;
    localparam int LANES  = ENT_W / DW_W;
    localparam int NPORT  = 2;

    typedef struct packed {
        logic            frz;
        logic [30:0]     rptr;
        logic [DW_W-1:0] rdata;
    } port_st_t;

    function automatic logic [DW_W-1:0] lane_pick(input logic [ENT_W-1:0] ent,
                                                   input logic [1:0] sel);
        return ent[sel*DW_W +: DW_W];
    endfunction
endpackage

// File: rtl/trace_ring_wptr.sv
module trace_ring_wptr #(
    parameter int DEPTH = 2048,
    parameter int NP    = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] frz_in,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_en = ~(|frz_in);
        if (wr_en) begin
            st_d.ptr = st_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_idx = st_q.ptr;
endmodule

// File: rtl/trace_ring_store.sv
module trace_ring_store #(
    parameter int DEPTH = 2048,
    parameter int NRD   = 2,
    localparam int EW   = trace_ring_pkg::ENT_W,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [EW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][EW-1:0]  rdata
);
    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        always_comb begin
            rdata[r] = mem[raddr[r]];
        end
    end
endmodule

// File: rtl/trace_ring_port.sv
module trace_ring_port
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam logic [30:0] RMASK = 31'(4 * DEPTH - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [63:0]      ctl_wdata,
    input  logic             data_re,
    input  logic [31:0]      wfield,
    input  logic [ENT_W-1:0] rd_entry,
    output logic [AW-1:0]    rd_idx,
    output logic             frz,
    output logic [63:0]      ctl_rdata,
    output logic [63:0]      data_rdata
);
    port_st_t st_d, st_q;
    logic     unused_hi;

    assign unused_hi = ^ctl_wdata[63:32];

    always_comb begin
        st_d = st_q;
        if (data_re) begin
            st_d.rdata = lane_pick(rd_entry, st_q.rptr[1:0]);
            st_d.rptr  = (st_q.rptr + 31'(1)) & RMASK;
        end
        if (ctl_we) begin
            st_d.frz  = ctl_wdata[31];
            st_d.rptr = ctl_wdata[30:0] & RMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx     = st_q.rptr[AW+1:2];
    assign frz        = st_q.frz;
    assign ctl_rdata  = {wfield, st_q.frz, st_q.rptr};
    assign data_rdata = st_q.rdata;
endmodule

// File: rtl/trace_ring.sv
module trace_ring
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [255:0] trace_in,
    input  logic         sw_ctl_we,
    input  logic [63:0]  sw_ctl_wdata,
    input  logic         sw_data_re,
    output logic [63:0]  sw_ctl_rdata,
    output logic [63:0]  sw_data_rdata,
    input  logic         dbg_ctl_we,
    input  logic [63:0]  dbg_ctl_wdata,
    input  logic         dbg_data_re,
    output logic [63:0]  dbg_ctl_rdata,
    output logic [63:0]  dbg_data_rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    if (DEPTH > 0) begin : g_cap
        logic                        wr_en;
        logic [AW-1:0]               wr_idx;
        logic [31:0]                 wfield;
        logic [NPORT-1:0]            frz;
        logic [NPORT-1:0]            p_we;
        logic [NPORT-1:0]            p_re;
        logic [NPORT-1:0][63:0]      p_wdata;
        logic [NPORT-1:0][63:0]      p_ctl;
        logic [NPORT-1:0][63:0]      p_dat;
        logic [NPORT-1:0][AW-1:0]    p_idx;
        logic [NPORT-1:0][ENT_W-1:0] p_ent;

        assign p_we    = {dbg_ctl_we, sw_ctl_we};
        assign p_re    = {dbg_data_re, sw_data_re};
        assign p_wdata = {dbg_ctl_wdata, sw_ctl_wdata};
        assign wfield  = 32'(DEPTH) | 32'(wr_idx);

        trace_ring_wptr #(.DEPTH(DEPTH), .NP(NPORT)) u_wptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .frz_in (frz),
            .wr_en  (wr_en),
            .wr_idx (wr_idx)
        );

        trace_ring_store #(.DEPTH(DEPTH), .NRD(NPORT)) u_store (
            .clk   (clk),
            .we    (wr_en),
            .waddr (wr_idx),
            .wdata (trace_in),
            .raddr (p_idx),
            .rdata (p_ent)
        );

        for (genvar p = 0; p < NPORT; p++) begin : g_port
            trace_ring_port #(.DEPTH(DEPTH)) u_port (
                .clk        (clk),
                .rst_n      (rst_n),
                .ctl_we     (p_we[p]),
                .ctl_wdata  (p_wdata[p]),
                .data_re    (p_re[p]),
                .wfield     (wfield),
                .rd_entry   (p_ent[p]),
                .rd_idx     (p_idx[p]),
                .frz        (frz[p]),
                .ctl_rdata  (p_ctl[p]),
                .data_rdata (p_dat[p])
            );
        end

        assign sw_ctl_rdata   = p_ctl[0];
        assign sw_data_rdata  = p_dat[0];
        assign dbg_ctl_rdata  = p_ctl[1];
        assign dbg_data_rdata = p_dat[1];
    end else begin : g_none
        assign sw_ctl_rdata   = '0;
        assign sw_data_rdata  = '0;
        assign dbg_ctl_rdata  = '0;
        assign dbg_data_rdata = '0;
    end
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk #(
    parameter int DEPTH = 2048
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sw_ctl_we,
    input logic [63:0]  sw_ctl_wdata,
    input logic         sw_data_re,
    input logic [63:0]  sw_ctl_rdata,
    input logic [63:0]  sw_data_rdata,
    input logic         dbg_ctl_we,
    input logic         dbg_data_re,
    input logic [63:0]  dbg_ctl_rdata
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int RPW = AW + 2;

    if (DEPTH > 0) begin : g_chk
        // R1
        advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(sw_ctl_rdata[31] || dbg_ctl_rdata[31]) |=>
            sw_ctl_rdata[32 +: AW] == AW'($past(sw_ctl_rdata[32 +: AW]) + AW'(1)));

        // R5
        frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_ctl_rdata[31] || dbg_ctl_rdata[31]) |=> $stable(sw_ctl_rdata[63:32]));

        // R4
        frz_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sw_ctl_we |=> sw_ctl_rdata[31] == $past(sw_ctl_wdata[31]));

        // R6
        cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_data_re && !sw_ctl_we) |=>
            sw_ctl_rdata[RPW-1:0] == RPW'($past(sw_ctl_rdata[RPW-1:0]) + RPW'(1)));

        // R6
        data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sw_data_re |=> $stable(sw_data_rdata));

        // R7
        dbg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!dbg_data_re && !dbg_ctl_we) |=> $stable(dbg_ctl_rdata[30:0]));
    end
endmodule

bind trace_ring trace_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_ctl_we     (sw_ctl_we),
    .sw_ctl_wdata  (sw_ctl_wdata),
    .sw_data_re    (sw_data_re),
    .sw_ctl_rdata  (sw_ctl_rdata),
    .sw_data_rdata (sw_data_rdata),
    .dbg_ctl_we    (dbg_ctl_we),
    .dbg_data_re   (dbg_data_re),
    .dbg_ctl_rdata (dbg_ctl_rdata)
);

// File: tb/trace_ring_bench.sv
module trace_ring_bench;
    localparam int D  = 16;
    localparam int ND = 4 * D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] trace_in = '0;
    logic         sw_ctl_we = 1'b0, sw_data_re = 1'b0;
    logic         dbg_ctl_we = 1'b0, dbg_data_re = 1'b0;
    logic [63:0]  sw_ctl_wdata = '0, dbg_ctl_wdata = '0;
    logic [63:0]  sw_ctl_rdata, sw_data_rdata, dbg_ctl_rdata, dbg_data_rdata;
    logic [63:0]  z_ctl_a, z_dat_a, z_ctl_b, z_dat_b;

    int tests = 0;
    int fails = 0;

    logic [255:0] mdl [D];
    int           mw = 0;
    logic         mf_sw = 1'b0, mf_dbg = 1'b0;
    int           sw_rp = 0, dbg_rp = 0;
    logic [63:0]  q_sw[$];
    logic [63:0]  q_dbg[$];
    int unsigned  cyc = 0;

    always #4 clk = ~clk;

    trace_ring #(.DEPTH(D)) u_trace_ring (
        .clk(clk), .rst_n(rst_n), .trace_in(trace_in),
        .sw_ctl_we(sw_ctl_we), .sw_ctl_wdata(sw_ctl_wdata), .sw_data_re(sw_data_re),
        .sw_ctl_rdata(sw_ctl_rdata), .sw_data_rdata(sw_data_rdata),
        .dbg_ctl_we(dbg_ctl_we), .dbg_ctl_wdata(dbg_ctl_wdata), .dbg_data_re(dbg_data_re),
        .dbg_ctl_rdata(dbg_ctl_rdata), .dbg_data_rdata(dbg_data_rdata)
    );

    trace_ring #(.DEPTH(0)) u_trace_ring_zero (
        .clk(clk), .rst_n(rst_n), .trace_in(trace_in),
        .sw_ctl_we(sw_ctl_we), .sw_ctl_wdata(sw_ctl_wdata), .sw_data_re(sw_data_re),
        .sw_ctl_rdata(z_ctl_a), .sw_data_rdata(z_dat_a),
        .dbg_ctl_we(dbg_ctl_we), .dbg_ctl_wdata(dbg_ctl_wdata), .dbg_data_re(dbg_data_re),
        .dbg_ctl_rdata(z_ctl_b), .dbg_data_rdata(z_dat_b)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // trace word generator: lane l = {l, C0FFEE, cycle}
    always @(negedge clk) begin
        cyc <= cyc + 1;
        for (int l = 0; l < 4; l++) trace_in[l*64 +: 64] <= {8'(l), 24'hC0FFEE, cyc};
    end

    // model of the store and scoreboard monitor
    always @(posedge clk) begin
        logic rs, rd;
        rs = sw_data_re;
        rd = dbg_data_re;
        if (rst_n) begin
            if (!(mf_sw || mf_dbg)) begin
                mdl[mw] = trace_in;
                mw = (mw + 1) % D;
            end
            if (sw_ctl_we)  mf_sw  = sw_ctl_wdata[31];
            if (dbg_ctl_we) mf_dbg = dbg_ctl_wdata[31];
        end
        #1;
        if (rst_n && rs) begin
            logic [63:0] e;
            e = q_sw.pop_front();
            chk(sw_data_rdata == e, "R6 sw readout", sw_data_rdata, e);
        end
        if (rst_n && rd) begin
            logic [63:0] e;
            e = q_dbg.pop_front();
            chk(dbg_data_rdata == e, "R7 dbg readout", dbg_data_rdata, e);
        end
    end

    function automatic logic [63:0] exp_dw(input int rp);
        return mdl[(rp >> 2) % D][(rp % 4) * 64 +: 64];
    endfunction

    task automatic ctl_sw(input bit f, input int rp, input logic [31:0] hi);
        sw_ctl_we = 1'b1;
        sw_ctl_wdata = {hi, f, 31'(rp)};
        @(negedge clk);
        sw_ctl_we = 1'b0;
        sw_rp = rp % ND;
    endtask

    task automatic ctl_dbg(input bit f, input int rp);
        dbg_ctl_we = 1'b1;
        dbg_ctl_wdata = {32'hDEAD_BEEF, f, 31'(rp)};
        @(negedge clk);
        dbg_ctl_we = 1'b0;
        dbg_rp = rp % ND;
    endtask

    task automatic rd_sw(input int n);
        for (int i = 0; i < n; i++) begin
            q_sw.push_back(exp_dw(sw_rp));
            sw_data_re = 1'b1;
            @(negedge clk);
            sw_rp = (sw_rp + 1) % ND;
        end
        sw_data_re = 1'b0;
    endtask

    task automatic rd_dbg(input int n);
        for (int i = 0; i < n; i++) begin
            q_dbg.push_back(exp_dw(dbg_rp));
            dbg_data_re = 1'b1;
            @(negedge clk);
            dbg_rp = (dbg_rp + 1) % ND;
        end
        dbg_data_re = 1'b0;
    endtask

    function automatic logic [63:0] wexp();
        return {32'(D) | 32'(mw), 32'h0};
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] hold, w0;
        int hb, len;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(sw_ctl_rdata == {32'(D), 32'h0}, "R8 sw ctl reset", sw_ctl_rdata, {32'(D), 32'h0});
        chk(dbg_ctl_rdata == {32'(D), 32'h0}, "R8 dbg ctl reset", dbg_ctl_rdata, {32'(D), 32'h0});
        chk(sw_data_rdata == 64'h0, "R8 data reset", sw_data_rdata, 64'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 R2 capture index advances
        chk(sw_ctl_rdata[63:32] == wexp() >> 32, "R1 index after 5", sw_ctl_rdata, wexp());
        repeat (30) @(negedge clk);
        chk(sw_ctl_rdata[63:32] == wexp() >> 32, "R1 index wrap", sw_ctl_rdata, wexp());
        // R2 length decode
        hb = 0;
        for (int b = 0; b < 64; b++) if (sw_ctl_rdata[b]) hb = b;
        len = 1 << (31 - (63 - hb));
        chk(len == D, "R2 length decode", 64'(len), 64'(D));
        // R4 R3 freeze via sw, upper write bits ignored
        ctl_sw(1'b1, 0, 32'hFFFF_FFFF);
        chk(sw_ctl_rdata[31:0] == 32'h8000_0000, "R3 sw flag and cursor", {32'h0, sw_ctl_rdata[31:0]}, 64'h8000_0000);
        w0 = sw_ctl_rdata;
        chk(w0[63:32] == wexp() >> 32, "R4 upper write ignored", w0, wexp());
        repeat (10) @(negedge clk);
        chk(sw_ctl_rdata[63:32] == w0[63:32], "R5 sw halt holds", sw_ctl_rdata, w0);
        // R6 full readout with cursor wrap
        rd_sw(ND + 3);
        chk(sw_ctl_rdata[30:0] == 31'(3), "R6 cursor wrap", {33'h0, sw_ctl_rdata[30:0]}, 64'd3);
        hold = sw_data_rdata;
        repeat (4) @(negedge clk);
        chk(sw_data_rdata == hold, "R6 data holds", sw_data_rdata, hold);
        // R7 debug port independent
        ctl_dbg(1'b0, 37);
        chk(dbg_ctl_rdata[31:0] == 32'd37, "R7 dbg cursor", {32'h0, dbg_ctl_rdata[31:0]}, 64'd37);
        chk(sw_ctl_rdata[30:0] == 31'(3), "R7 sw cursor untouched", {33'h0, sw_ctl_rdata[30:0]}, 64'd3);
        rd_dbg(5);
        chk(sw_data_rdata == hold, "R7 sw data untouched", sw_data_rdata, hold);
        // R5 dbg halts, sw releases: still halted
        ctl_dbg(1'b1, 2);
        ctl_sw(1'b0, 0, 32'h0);
        repeat (6) @(negedge clk);
        chk(sw_ctl_rdata[63:32] == w0[63:32], "R5 either flag halts", sw_ctl_rdata, w0);
        rd_dbg(4);
        // R5 R1 release both: capture resumes
        ctl_dbg(1'b0, 0);
        repeat (3) @(negedge clk);
        chk(sw_ctl_rdata[63:32] == wexp() >> 32, "R5 resume", sw_ctl_rdata, wexp());
        chk(sw_ctl_rdata[63:32] != w0[63:32], "R1 moved after resume", sw_ctl_rdata, wexp());
        // freeze again and read newest entry area
        ctl_sw(1'b1, 4 * ((mw + D - 1) % D), 32'h0);
        rd_sw(4);
        // R9 zero-depth instance
        chk((z_ctl_a | z_dat_a | z_ctl_b | z_dat_b) == 64'h0, "R9 zero depth", z_ctl_a | z_dat_a, 64'h0);
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule